// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Flag Generator

This block sits beside a dual-clock FIFO and turns its pointers into two threshold flags. On the read clock it drives an active-low almost-empty flag. The flag compares the number of words still held in memory with a programmable empty offset. On the write clock it drives an active-low almost-full flag. That flag compares the number of free locations with a programmable full offset. The surrounding FIFO provides both pointers to each domain, with the remote pointer already synchronized. The read pointer advances whenever a word moves into the FIFO output register, so a word that waits in that register is not counted as stored. The storage array is not part of this block.

There are three ways to set the two offsets. On reset both take a preset value picked by a two-bit select. While the block is in parallel mode, a valid/ready configuration stream can overwrite either offset. In serial mode both offsets are shifted in one bit per write clock. Then `prog_done` rises, which tells the FIFO that normal writes may start. The offsets belong to the write clock domain. The read domain treats the empty offset as quasi-static, so it must be programmed before FIFO traffic begins.

Top module: `almost_flag_gen`

## Requirements
- R1: `almost_empty_n` is 1 when the stored count `fill = (wr_ptr_rsync - rd_ptr) mod 2^(AW+1)` is larger than the empty offset X, and 0 when `fill <= X`. A word that has already moved to the output register has advanced `rd_ptr`, so it is not counted.
- R2: `almost_full_n` is 1 when the free space `DEPTH - fill` is larger than the full offset Y, where `fill = (wr_ptr - rd_ptr_wsync) mod 2^(AW+1)`. It is 0 when the free space is Y or less.
- R3: A pointer or offset change that is set up before a clock edge shows on the flag of that clock's domain at the second rising edge. At the first edge the flag still shows the old result.
- R4: While reset is asserted, and until the pipeline has filled, both flags are 0.
- R5: Reset loads both offsets from `preset_sel`: 2'b00 gives 8, 2'b01 gives 16, 2'b10 gives 64, and 2'b11 gives 8.
- R6: While `ser_mode` is 0, `cfg_ready` is 1. A transfer happens on a write clock edge when `cfg_valid` and `cfg_ready` are both 1. `cfg_sel` = 0 writes `cfg_data` into X and `cfg_sel` = 1 writes it into Y. While `ser_mode` is 1, `cfg_ready` is 0 and `cfg_valid` has no effect.
- R7: While `ser_mode` is 1, each write clock edge with `ser_en` = 1 shifts in `ser_in`. The first AW bits set X, MSB first, and the next AW bits set Y, MSB first. Once all 2*AW bits are in, `prog_done` rises at that same edge, and any later `ser_en` has no effect.
- R8: `prog_done` is 1 straight out of reset in parallel mode and 0 straight out of reset in serial mode. Once it is 1 it stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side asynchronous reset, active low |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read-side asynchronous reset, active low |
| preset_sel | input | 2 | Selects the reset offset value |
| ser_mode | input | 1 | 1 = serial offset programming, 0 = parallel |
| cfg_valid | input | 1 | Configuration stream valid |
| cfg_ready | output | 1 | Configuration stream ready |
| cfg_sel | input | 1 | 0 = empty offset, 1 = full offset |
| cfg_data | input | AW | Offset value to write |
| ser_en | input | 1 | Serial shift enable |
| ser_in | input | 1 | Serial offset bit |
| wr_ptr | input | AW+1 | Write pointer, write domain |
| rd_ptr_wsync | input | AW+1 | Read pointer synchronized to the write clock |
| rd_ptr | input | AW+1 | Read pointer, read domain |
| wr_ptr_rsync | input | AW+1 | Write pointer synchronized to the read clock |
| almost_empty_n | output | 1 | Low when X or fewer words are stored |
| almost_full_n | output | 1 | Low when Y or fewer locations are free |
| prog_done | output | 1 | Offset programming complete |

## Verification
A pointer change becomes visible on the flags at the second clock edge, two cycles after it is applied. The bench drives all inputs on falling edges. After the first rising edge it confirms that each flag still holds the previously expected value. After the second rising edge it checks the newly expected value. A configuration transfer or serial bit is registered in one cycle, so `cfg_ready` and `prog_done` are checked at the falling edge right after the edge that consumes the bit. The flag effect of a new offset is then checked after a further two edges.

// File: rtl/afg_pkg.sv
package afg_pkg;

  typedef enum logic [1:0] {
    PRE_LOW  = 2'b00,
    PRE_MID  = 2'b01,
    PRE_HIGH = 2'b10,
    PRE_SPARE = 2'b11
  } preset_e;

  localparam int unsigned PRE_LOW_VAL  = 8;
  localparam int unsigned PRE_MID_VAL  = 16;
  localparam int unsigned PRE_HIGH_VAL = 64;

  function automatic int unsigned preset_value(input logic [1:0] sel);
    case (preset_e'(sel))
      PRE_MID:  return PRE_MID_VAL;
      PRE_HIGH: return PRE_HIGH_VAL;
      default:  return PRE_LOW_VAL;
    endcase
  endfunction

endpackage

// File: rtl/afg_level_flag.sv
module afg_level_flag #(
  parameter int unsigned AW        = 7,
  parameter int unsigned OW        = 7,
  parameter bit          FREE_SIDE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW:0]   local_ptr,
  input  logic [AW:0]   remote_ptr,
  input  logic [OW-1:0] offset,
  output logic          flag
);
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;
  localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);

  logic [PW-1:0] fill;
  logic [PW-1:0] level;
  logic          above;
  logic          stage1;
  logic [1:0]    warm;

  generate
    if (FREE_SIDE) begin : g_free
      assign fill  = local_ptr - remote_ptr;
      assign level = DEPTH_V - fill;
    end else begin : g_fill
      assign fill  = remote_ptr - local_ptr;
      assign level = fill;
    end
  endgenerate

  assign above = ({1'b0, level} > {{(PW + 1 - OW){1'b0}}, offset});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= 1'b0;
      flag   <= 1'b0;
      warm   <= 2'd0;
    end else begin
      stage1 <= above;
      flag   <= stage1;
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end

  a_r3_two_edge_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> (flag == $past(above, 2)));

  a_r4_low_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd0) |-> !flag);

endmodule

// File: rtl/afg_offsets.sv
module afg_offsets #(
  parameter int unsigned OW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    preset_sel,
  input  logic          ser_mode,
  input  logic          cfg_valid,
  output logic          cfg_ready,
  input  logic          cfg_sel,
  input  logic [OW-1:0] cfg_data,
  input  logic          ser_en,
  input  logic          ser_in,
  output logic [OW-1:0] ae_off,
  output logic [OW-1:0] af_off,
  output logic          prog_done
);
  import afg_pkg::*;

  localparam int unsigned NBITS = 2 * OW;
  localparam int unsigned CW    = $clog2(NBITS + 1);
  localparam logic [CW-1:0] LAST = CW'(NBITS - 1);

  logic [CW-1:0] bit_cnt;
  logic          shift_now;
  logic          cfg_fire;

  assign cfg_ready = !ser_mode;
  assign cfg_fire  = cfg_valid && cfg_ready;
  assign shift_now = ser_mode && ser_en && !prog_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_off    <= OW'(preset_value(preset_sel));
      af_off    <= OW'(preset_value(preset_sel));
      prog_done <= !ser_mode;
      bit_cnt   <= '0;
    end else if (shift_now) begin
      {ae_off, af_off} <= {ae_off[OW-2:0], af_off, ser_in};
      bit_cnt          <= bit_cnt + 1'b1;
      if (bit_cnt == LAST) prog_done <= 1'b1;
    end else if (cfg_fire) begin
      if (cfg_sel) af_off <= cfg_data;
      else         ae_off <= cfg_data;
    end
  end

  a_r8_done_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> prog_done);

  a_r7_done_after_shift: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_done) |-> $past(ser_en) && $past(ser_mode));

  a_r7_frozen_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_mode && prog_done && $past(prog_done)) |-> ($stable(ae_off) && $stable(af_off)));

  a_r6_no_parallel_in_serial: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_mode && !ser_en && $past(ser_mode) && !$past(ser_en)) |=> ($stable(ae_off) && $stable(af_off)));

endmodule

// File: rtl/almost_flag_gen.sv
module almost_flag_gen #(
  parameter int unsigned AW = 7
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic [1:0]    preset_sel,
  input  logic          ser_mode,
  input  logic          cfg_valid,
  output logic          cfg_ready,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_data,
  input  logic          ser_en,
  input  logic          ser_in,
  input  logic [AW:0]   wr_ptr,
  input  logic [AW:0]   rd_ptr_wsync,
  input  logic [AW:0]   rd_ptr,
  input  logic [AW:0]   wr_ptr_rsync,
  output logic          almost_empty_n,
  output logic          almost_full_n,
  output logic          prog_done
);
  localparam int unsigned OW = AW;

  logic [OW-1:0] ae_off;
  logic [OW-1:0] af_off;

  afg_offsets #(.OW(OW)) u_offsets (
    .clk        (wclk),
    .rst_n      (wrst_n),
    .preset_sel (preset_sel),
    .ser_mode   (ser_mode),
    .cfg_valid  (cfg_valid),
    .cfg_ready  (cfg_ready),
    .cfg_sel    (cfg_sel),
    .cfg_data   (cfg_data),
    .ser_en     (ser_en),
    .ser_in     (ser_in),
    .ae_off     (ae_off),
    .af_off     (af_off),
    .prog_done  (prog_done)
  );

  afg_level_flag #(.AW(AW), .OW(OW), .FREE_SIDE(1'b0)) u_empty (
    .clk        (rclk),
    .rst_n      (rrst_n),
    .local_ptr  (rd_ptr),
    .remote_ptr (wr_ptr_rsync),
    .offset     (ae_off),
    .flag       (almost_empty_n)
  );

  afg_level_flag #(.AW(AW), .OW(OW), .FREE_SIDE(1'b1)) u_full (
    .clk        (wclk),
    .rst_n      (wrst_n),
    .local_ptr  (wr_ptr),
    .remote_ptr (rd_ptr_wsync),
    .offset     (af_off),
    .flag       (almost_full_n)
  );

endmodule

// File: tb/sim_almost_flag_gen.sv
module sim_almost_flag_gen;
  localparam int AW    = 7;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] preset_sel = 2'b00;
  logic ser_mode = 1'b0;
  logic cfg_valid = 1'b0;
  logic cfg_ready;
  logic cfg_sel = 1'b0;
  logic [AW-1:0] cfg_data = '0;
  logic ser_en = 1'b0;
  logic ser_in = 1'b0;
  logic [AW:0] wr_ptr = '0, rd_ptr_wsync = '0, rd_ptr = '0, wr_ptr_rsync = '0;
  logic almost_empty_n, almost_full_n, prog_done;

  int n_vec = 0;
  int n_bad = 0;
  int x_off, y_off;
  logic prev_ae, prev_af;
  bit finished = 0;

  always #2.5 clk = ~clk;

  almost_flag_gen #(.AW(AW)) u0 (
    .wclk(clk), .wrst_n(rst_n), .rclk(clk), .rrst_n(rst_n),
    .preset_sel(preset_sel), .ser_mode(ser_mode),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .ser_en(ser_en), .ser_in(ser_in),
    .wr_ptr(wr_ptr), .rd_ptr_wsync(rd_ptr_wsync), .rd_ptr(rd_ptr), .wr_ptr_rsync(wr_ptr_rsync),
    .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n), .prog_done(prog_done)
  );

  function automatic logic exp_ae(int fill, int x);
    return fill > x;
  endfunction

  function automatic logic exp_af(int fill, int y);
    return (DEPTH - fill) > y;
  endfunction

  function automatic int preset_of(logic [1:0] s);
    case (s)
      2'b01: return 16;
      2'b10: return 64;
      default: return 8;
    endcase
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // Set pointers for a given fill; flags due on the second rising edge.
  task automatic apply(input int fill, input bit lat_chk);
    int base;
    base = $urandom;
    @(negedge clk);
    rd_ptr       = (AW+1)'(base);
    wr_ptr_rsync = (AW+1)'(base + fill);
    wr_ptr       = (AW+1)'(base + fill);
    rd_ptr_wsync = (AW+1)'(base);
    @(posedge clk); @(negedge clk);
    if (lat_chk) begin
      check(almost_empty_n, prev_ae, "R3 empty flag unchanged after one edge");
      check(almost_full_n,  prev_af, "R3 full flag unchanged after one edge");
    end
    @(posedge clk); @(negedge clk);
    prev_ae = exp_ae(fill, x_off);
    prev_af = exp_af(fill, y_off);
    check(almost_empty_n, prev_ae, "R1 empty flag vs offset");
    check(almost_full_n,  prev_af, "R2 full flag vs offset");
  endtask

  task automatic do_reset(input logic [1:0] ps, input logic sm);
    @(negedge clk);
    rst_n = 1'b0; preset_sel = ps; ser_mode = sm;
    wr_ptr = '0; rd_ptr = '0; wr_ptr_rsync = '0; rd_ptr_wsync = '0;
    #1;
    check(almost_empty_n, 1'b0, "R4 empty flag low in reset");
    check(almost_full_n,  1'b0, "R4 full flag low in reset");
    check(prog_done, !sm, "R8 done state after reset");
    check(cfg_ready, !sm, "R6 ready follows mode");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(almost_full_n, 1'b0, "R4 flag low one edge after reset");
    x_off = preset_of(ps); y_off = preset_of(ps);
    prev_ae = 1'b0; prev_af = 1'b1;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic cfg_write(input logic sel, input int val);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_sel = sel; cfg_data = AW'(val);
    @(negedge clk);
    cfg_valid = 1'b0;
    if (cfg_ready) begin
      if (sel) y_off = val; else x_off = val;
    end
  endtask

  task automatic ser_load(input int xv, input int yv);
    logic [2*AW-1:0] word;
    word = {AW'(xv), AW'(yv)};
    for (int i = 2*AW-1; i >= 0; i--) begin
      @(negedge clk);
      ser_en = 1'b1; ser_in = word[i];
      if (i == 0) begin
        @(negedge clk);
        check(prog_done, 1'b1, "R7 done after last serial bit");
      end else if (i == 1) begin
        check(prog_done, 1'b0, "R7 done not early");
      end
    end
    ser_en = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    // Presets (R5) and boundaries at X/X+1 and free Y/Y+1.
    for (int ps = 0; ps < 4; ps++) begin
      do_reset(2'(ps), 1'b0);
      apply(x_off, 1'b1);
      check(almost_empty_n, 1'b0, "R5 preset empty offset at X");
      apply(x_off + 1, 1'b1);
      check(almost_empty_n, 1'b1, "R5 preset empty offset at X+1");
      apply(DEPTH - y_off, 1'b1);
      check(almost_full_n, 1'b0, "R5 preset full offset at free Y");
      apply(DEPTH - y_off - 1, 1'b1);
    end
    // Corners: empty and completely full.
    apply(0, 1'b1);
    apply(DEPTH, 1'b1);
    apply(DEPTH, 1'b1);
    // Parallel programming (R6).
    cfg_write(1'b0, 3);
    cfg_write(1'b1, 100);
    apply(3, 1'b0);
    check(almost_empty_n, 1'b0, "R6 new empty offset at 3");
    apply(4, 1'b1);
    apply(DEPTH - 100, 1'b1);
    apply(DEPTH - 101, 1'b1);
    // Random fills and offsets.
    for (int i = 0; i < 300; i++) begin
      if (i % 25 == 0) begin
        cfg_write(1'b0, $urandom_range(DEPTH - 1));
        cfg_write(1'b1, $urandom_range(DEPTH - 1));
        apply($urandom_range(DEPTH), 1'b0);
      end else begin
        apply($urandom_range(DEPTH), 1'b1);
      end
    end
    // Serial programming (R7, R8).
    do_reset(2'b10, 1'b1);
    apply(65, 1'b0);
    ser_load(5, 9);
    x_off = 5; y_off = 9;
    cfg_write(1'b0, 50);
    check(cfg_ready, 1'b0, "R6 ready low in serial mode");
    apply(5, 1'b0);
    check(almost_empty_n, 1'b0, "R7 serial empty offset at X");
    apply(6, 1'b1);
    check(almost_empty_n, 1'b1, "R6 parallel write ignored in serial mode");
    apply(DEPTH - 9, 1'b1);
    apply(DEPTH - 10, 1'b1);
    for (int i = 0; i < 2*AW; i++) begin
      @(negedge clk); ser_en = 1'b1; ser_in = 1'b1;
    end
    @(negedge clk); ser_en = 1'b0;
    check(prog_done, 1'b1, "R8 done stays high");
    apply(5, 1'b1);
    apply(6, 1'b1);
    check(almost_empty_n, 1'b1, "R7 extra serial bits ignored");
    apply(DEPTH - 9, 1'b1);
    finished = 1;
  end

  initial begin
    fork
      begin
        wait (finished);
      end
      begin
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule